// File: doc/BRIEF.md
# Programmable Event Counter with Threshold

This block is one programmable performance-monitoring counter. Every cycle a set of event lanes reports occurrences. Each lane carries a valid bit, an 8-bit event code and an 8-bit attribute byte. The low nibble of the attribute byte gives the line-state class and the high nibble gives the request type. A separate occupancy input reports how many requests are pending.

A configuration word chooses which events are selected and how they are counted. It holds an event code, a sub-event mask, a compare threshold, an invert flag, an edge flag and a global enable. From these the block forms a per-cycle selected count. It then adds either that raw count or a single qualified increment to a 48-bit counter. Software reads and writes both the configuration word and the counter through a small register port.

Threshold qualification in edge mode is handled by a two-state tracker. `QS_LOW` means the qualified condition was false in the previous counted cycle. `QS_HIGH` means it was true. The tracker has three transitions:
- *rise* (`QS_LOW` to `QS_HIGH`) is taken when the condition is true.
- *fall* (`QS_HIGH` to `QS_LOW`) is taken when the condition is false.
- *rearm* (any state to `QS_LOW`) is taken on every configuration write.

An edge-mode increment is issued only from `QS_LOW`.

Top module: `evt_threshold_counter`

## Requirements
- R1: After reset the counter reads 0 and the configuration word reads 0.
- R2: Configuration word layout is: bits [7:0] event code, [15:8] mask, [23:16] threshold, bit 24 invert, bit 25 edge, bit 26 enable. A lane is selected when it is valid, its code equals the configured code, and its attribute low nibble shares a set bit with the mask low nibble. Several mask bits count the union of their states, and the selected count is the number of selected lanes.
- R3: If the mask high nibble is nonzero, a lane must also share a set bit between its attribute high nibble and the mask high nibble. A mask whose low nibble is zero selects nothing.
- R4: When the configured code equals OCC_CODE (default 0x80), the selected count is `occ_level` and the lanes are ignored. This holds whenever the mask low nibble is nonzero; otherwise the selected count is 0.
- R5: With threshold 0, each enabled cycle adds the selected count, and the invert and edge flags have no effect.
- R6: With a nonzero threshold and invert clear, an enabled cycle adds 1 when the selected count is at least the threshold, and 0 otherwise.
- R7: With a nonzero threshold and invert set, an enabled cycle adds 1 when the selected count is below the threshold.
- R8: With a nonzero threshold and edge set, one increment is made per false-to-true change of the qualified condition, however long the condition stays true.
- R9: A configuration write returns the edge tracker to `QS_LOW`. A condition that is still true afterwards therefore counts once more in the first cycle after the write.
- R10: With enable clear the counter holds its value.
- R11: Writing address 1 loads the counter in the next cycle. This load takes priority over an increment in the same cycle. Reading address 1 returns the counter and address 0 returns the configuration word.
- R12: The counter wraps modulo 2^48.
- R13: A configuration write takes effect from the next cycle, so the cycle of the write is counted under the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_valid | input | NUM_LANES | Per-lane event occurrence |
| lane_code | input | 8*NUM_LANES | Per-lane event code, lane i at bits [8i+7:8i] |
| lane_attr | input | 8*NUM_LANES | Per-lane attribute: low nibble state, high nibble request type |
| occ_level | input | OCC_W | Requests currently pending |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = configuration word, 1 = counter |
| reg_wdata | input | CTR_W | Write data |
| reg_rdata | output | CTR_W | Read data for `reg_addr`, combinational |

## Verification
The bench builds the block with NUM_LANES = 3 and OCC_W = 5. With this build the lane count takes every value from 0 to 3, so thresholds 1 to 3 can be approached from both sides with and without inversion. The occupancy path reaches 31, well above any lane total. The 48-bit counter is preloaded close to its limit through the write port, which reaches the wrap boundary in a few cycles. Random configurations cover codes that select lanes, the occupancy code and a code that selects nothing, and they are checked against a bench model every cycle.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;

    localparam int CFG_W = 27;

    // Configuration word, packed so that its bit positions follow R2.
    typedef struct packed {
        logic       enable;     // 26
        logic       edge_mode;  // 25
        logic       invert;     // 24
        logic [7:0] thresh;     // 23:16
        logic [7:0] mask;       // 15:8
        logic [7:0] code;       // 7:0
    } evt_cfg_t;

    typedef enum logic [0:0] {
        QS_LOW  = 1'b0,
        QS_HIGH = 1'b1
    } qual_state_e;

endpackage

// File: rtl/evtcnt_select.sv
module evtcnt_select #(
    parameter int          NUM_LANES = 4,
    parameter int          OCC_W     = 6,
    parameter logic [7:0]  OCC_CODE  = 8'h80,
    parameter int          CNT_W     = 6
) (
    input  logic [7:0]             cfg_code,
    input  logic [7:0]             cfg_mask,
    input  logic [NUM_LANES-1:0]   lane_valid,
    input  logic [8*NUM_LANES-1:0] lane_code,
    input  logic [8*NUM_LANES-1:0] lane_attr,
    input  logic [OCC_W-1:0]       occ_level,
    output logic [CNT_W-1:0]       sel_count
);

    logic [NUM_LANES-1:0] hit;
    logic [CNT_W-1:0]     lane_sum;
    logic                 state_any;
    logic                 filt_on;

    assign state_any = |cfg_mask[3:0];
    assign filt_on   = |cfg_mask[7:4];

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [7:0] l_code;
        logic [7:0] l_attr;
        logic       state_ok;
        logic       type_ok;
        assign l_code   = lane_code[8*g +: 8];
        assign l_attr   = lane_attr[8*g +: 8];
        assign state_ok = |(l_attr[3:0] & cfg_mask[3:0]);
        assign type_ok  = !filt_on || (|(l_attr[7:4] & cfg_mask[7:4]));
        assign hit[g]   = lane_valid[g] && (l_code == cfg_code) && state_ok && type_ok;
    end

    always_comb begin
        lane_sum = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            lane_sum = lane_sum + CNT_W'(hit[i]);
        end
    end

    always_comb begin
        if (cfg_code == OCC_CODE) begin
            sel_count = state_any ? CNT_W'(occ_level) : '0;
        end else begin
            sel_count = lane_sum;
        end
    end

endmodule

// File: rtl/evtcnt_qualify.sv
module evtcnt_qualify
    import evtcnt_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [7:0]       thresh,
    input  logic             invert,
    input  logic             edge_mode,
    input  logic             enable,
    input  logic [CNT_W-1:0] sel_count,
    output logic [CNT_W-1:0] inc
);

    localparam int CW = (CNT_W > 8) ? CNT_W : 8;

    logic [CW-1:0] cnt_x;
    logic [CW-1:0] thr_x;
    logic          thr_on;
    logic          cmp;
    logic          cond;
    qual_state_e   st_q;
    qual_state_e   st_d;

    assign cnt_x  = CW'(sel_count);
    assign thr_x  = CW'(thresh);
    assign thr_on = |thresh;
    assign cmp    = invert ? (cnt_x < thr_x) : (cnt_x >= thr_x);
    assign cond   = enable && thr_on && cmp;

    // next state: rise, fall, rearm
    always_comb begin
        st_d = st_q;
        if (cfg_load) begin
            st_d = QS_LOW;
        end else begin
            unique case (st_q)
                QS_LOW:  if (cond)  st_d = QS_HIGH;
                QS_HIGH: if (!cond) st_d = QS_LOW;
                default: st_d = QS_LOW;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= QS_LOW;
        end else begin
            st_q <= st_d;
        end
    end

    // outputs
    always_comb begin
        inc = '0;
        if (enable) begin
            if (!thr_on) begin
                inc = sel_count;
            end else begin
                unique case (st_q)
                    QS_LOW:  inc = CNT_W'(cond);
                    QS_HIGH: inc = edge_mode ? '0 : CNT_W'(cond);
                    default: inc = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/evtcnt_accum.sv
module evtcnt_accum #(
    parameter int CTR_W = 48,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTR_W-1:0] wr_data,
    input  logic [CNT_W-1:0] inc,
    output logic [CTR_W-1:0] value
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr_en) begin
            value <= wr_data;
        end else begin
            value <= value + CTR_W'(inc);
        end
    end

endmodule

// File: rtl/evt_threshold_counter.sv
module evt_threshold_counter
    import evtcnt_pkg::*;
#(
    parameter int         NUM_LANES = 4,
    parameter int         OCC_W     = 6,
    parameter logic [7:0] OCC_CODE  = 8'h80,
    parameter int         CTR_W     = 48
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LANES-1:0]   lane_valid,
    input  logic [8*NUM_LANES-1:0] lane_code,
    input  logic [8*NUM_LANES-1:0] lane_attr,
    input  logic [OCC_W-1:0]       occ_level,
    input  logic                   reg_wr,
    input  logic                   reg_addr,
    input  logic [CTR_W-1:0]       reg_wdata,
    output logic [CTR_W-1:0]       reg_rdata
);

    localparam int LANE_CW = $clog2(NUM_LANES + 1);
    localparam int CNT_W   = (LANE_CW > OCC_W) ? LANE_CW : OCC_W;

    evt_cfg_t         cfg_q;
    logic [CFG_W-1:0] cfg_bits;
    logic             cfg_load;
    logic             ctr_load;
    logic [CNT_W-1:0] sel_count;
    logic [CNT_W-1:0] inc;
    logic [CTR_W-1:0] ctr_value;

    assign cfg_load = reg_wr && !reg_addr;
    assign ctr_load = reg_wr && reg_addr;
    assign cfg_bits = cfg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_load) begin
            cfg_q <= evt_cfg_t'(reg_wdata[CFG_W-1:0]);
        end
    end

    evtcnt_select #(
        .NUM_LANES(NUM_LANES), .OCC_W(OCC_W), .OCC_CODE(OCC_CODE), .CNT_W(CNT_W)
    ) u_select (
        .cfg_code(cfg_q.code), .cfg_mask(cfg_q.mask),
        .lane_valid(lane_valid), .lane_code(lane_code), .lane_attr(lane_attr),
        .occ_level(occ_level), .sel_count(sel_count)
    );

    evtcnt_qualify #(.CNT_W(CNT_W)) u_qualify (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .thresh(cfg_q.thresh), .invert(cfg_q.invert),
        .edge_mode(cfg_q.edge_mode), .enable(cfg_q.enable),
        .sel_count(sel_count), .inc(inc)
    );

    evtcnt_accum #(.CTR_W(CTR_W), .CNT_W(CNT_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .wr_en(ctr_load), .wr_data(reg_wdata),
        .inc(inc), .value(ctr_value)
    );

    assign reg_rdata = reg_addr ? ctr_value : CTR_W'(cfg_bits);

endmodule

// File: rtl/evtcnt_checker.sv
module evtcnt_checker #(
    parameter int CTR_W = 48,
    parameter int CFG_W = 27
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_addr,
    input logic [CTR_W-1:0] reg_wdata,
    input logic [CTR_W-1:0] ctr_value,
    input logic [CFG_W-1:0] cfg_bits
);

    logic en_on, edge_on, thr_on;
    assign en_on   = cfg_bits[26];
    assign edge_on = cfg_bits[25];
    assign thr_on  = |cfg_bits[23:16];

    AST_CTR_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr) |=> (ctr_value == $past(reg_wdata))); // R11

    AST_CFG_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr) |=> (cfg_bits == $past(reg_wdata[CFG_W-1:0]))); // R13

    AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && !reg_addr) |=> $stable(cfg_bits)); // R13

    AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_on && !(reg_wr && reg_addr)) |=> $stable(ctr_value)); // R10

    AST_QUAL_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_on && thr_on && !(reg_wr && reg_addr)) |=> ((ctr_value - $past(ctr_value)) <= CTR_W'(1))); // R6

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_on && edge_on && thr_on && !reg_wr && $past(!reg_wr)
         && (ctr_value != $past(ctr_value))) |=> $stable(ctr_value)); // R8

endmodule

bind evt_threshold_counter evtcnt_checker #(.CTR_W(CTR_W), .CFG_W(27)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ctr_value(ctr_value), .cfg_bits(cfg_bits)
);

// File: tb/evt_threshold_counter_test.sv
module evt_threshold_counter_test;

    localparam int CLK_P = 10;
    localparam int NL    = 3;
    localparam int OW    = 5;
    localparam int CW    = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] lane_valid = '0;
    logic [8*NL-1:0] lane_code = '0;
    logic [8*NL-1:0] lane_attr = '0;
    logic [OW-1:0] occ_level = '0;
    logic          reg_wr = 1'b0;
    logic          reg_addr = 1'b1;
    logic [CW-1:0] reg_wdata = '0;
    logic [CW-1:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [26:0]   m_cfg = '0;
    logic [CW-1:0] m_ctr = '0;
    bit            m_prev = 0;

    always #(CLK_P/2) clk = ~clk;

    evt_threshold_counter #(.NUM_LANES(NL), .OCC_W(OW), .OCC_CODE(8'h80), .CTR_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .lane_valid(lane_valid), .lane_code(lane_code),
        .lane_attr(lane_attr), .occ_level(occ_level), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [CW-1:0] mk_cfg(logic [7:0] code, logic [7:0] mask, logic [7:0] thr,
                                             bit inv, bit ed, bit en);
        return CW'({en, ed, inv, thr, mask, code});
    endfunction

    function automatic int model_count();
        int n = 0;
        logic [7:0] code = m_cfg[7:0];
        logic [7:0] mask = m_cfg[15:8];
        if (code == 8'h80) return (mask[3:0] != 0) ? int'(occ_level) : 0;
        for (int i = 0; i < NL; i++) begin
            logic [7:0] c = lane_code[8*i +: 8];
            logic [7:0] a = lane_attr[8*i +: 8];
            if (lane_valid[i] && c == code && (a[3:0] & mask[3:0]) != 0 &&
                (mask[7:4] == 0 || (a[7:4] & mask[7:4]) != 0)) n++;
        end
        return n;
    endfunction

    task automatic tick();
        int c = model_count();
        int thr = int'(m_cfg[23:16]);
        bit inv = m_cfg[24], ed = m_cfg[25], en = m_cfg[26];
        bit cond = en && thr != 0 && (inv ? (c < thr) : (c >= thr));
        int inc = 0;
        if (en) inc = (thr == 0) ? c : ((cond && !(ed && m_prev)) ? 1 : 0);
        @(posedge clk);
        if (reg_wr && reg_addr) m_ctr = reg_wdata;
        else m_ctr = m_ctr + CW'(inc);
        if (reg_wr && !reg_addr) begin m_cfg = reg_wdata[26:0]; m_prev = 0; end
        else m_prev = cond;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_addr = 1'b1;
    endtask

    task automatic check_val(string req, logic [CW-1:0] got, logic [CW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic chk_ctr(string req);
        reg_addr = 1'b1;
        #1;
        check_val(req, reg_rdata, m_ctr);
    endtask

    task automatic wr_cfg(logic [CW-1:0] v);
        reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = v;
        tick();
    endtask

    task automatic wr_ctr(logic [CW-1:0] v);
        reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = v;
        tick();
    endtask

    task automatic lanes(logic [NL-1:0] v, logic [8*NL-1:0] c, logic [8*NL-1:0] a, logic [OW-1:0] o);
        lane_valid = v; lane_code = c; lane_attr = a; occ_level = o;
    endtask

    function automatic logic [7:0] pick_code();
        case ($urandom % 4)
            0: return 8'h22;
            1: return 8'h34;
            2: return 8'h80;
            default: return 8'h55;
        endcase
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_ctr("R1 counter");
        reg_addr = 1'b0; #1; check_val("R1 config", reg_rdata, '0); reg_addr = 1'b1;

        // R2 union of state bits 1 and 2
        wr_cfg(mk_cfg(8'h34, 8'h06, 8'd0, 0, 0, 1));
        lanes(3'b111, {8'h34, 8'h34, 8'h34}, {8'h08, 8'h04, 8'h02}, 5'd0);
        tick(); chk_ctr("R2 union");
        check_val("R2 absolute", reg_rdata, 48'd2);
        lanes(3'b101, {8'h34, 8'h34, 8'h22}, {8'h02, 8'h02, 8'h02}, 5'd0);
        tick(); chk_ctr("R2 code/valid");

        // R3 filters
        wr_cfg(mk_cfg(8'h34, 8'h14, 8'd0, 0, 0, 1));
        lanes(3'b111, {8'h34, 8'h34, 8'h34}, {8'h14, 8'h24, 8'h11}, 5'd0);
        tick(); chk_ctr("R3 filter");
        wr_cfg(mk_cfg(8'h34, 8'hF0, 8'd0, 0, 0, 1));
        tick(); chk_ctr("R3 no state bits");

        // R4 occupancy
        wr_cfg(mk_cfg(8'h80, 8'h01, 8'd0, 0, 0, 1));
        lanes(3'b111, {8'h80, 8'h80, 8'h80}, {8'h01, 8'h01, 8'h01}, 5'd17);
        tick(); chk_ctr("R4 occupancy");
        lanes(3'b000, '0, '0, 5'd31);
        tick(); chk_ctr("R4 occupancy max");
        wr_cfg(mk_cfg(8'h80, 8'h10, 8'd0, 0, 0, 1));
        tick(); chk_ctr("R4 no state bits");

        // R5 raw mode, invert and edge ignored
        wr_cfg(mk_cfg(8'h80, 8'h01, 8'd0, 1, 1, 1));
        lanes(3'b000, '0, '0, 5'd9);
        tick(); tick(); chk_ctr("R5 raw with inv/edge");

        // R6 threshold 2
        wr_cfg(mk_cfg(8'h34, 8'h01, 8'd2, 0, 0, 1));
        lanes(3'b001, {8'h34, 8'h34, 8'h34}, {8'h01, 8'h01, 8'h01}, 5'd0);
        tick(); chk_ctr("R6 below");
        lanes(3'b011, {8'h34, 8'h34, 8'h34}, {8'h01, 8'h01, 8'h01}, 5'd0);
        tick(); chk_ctr("R6 equal");
        lanes(3'b111, {8'h34, 8'h34, 8'h34}, {8'h01, 8'h01, 8'h01}, 5'd0);
        tick(); chk_ctr("R6 above");

        // R7 invert
        wr_cfg(mk_cfg(8'h34, 8'h01, 8'd2, 1, 0, 1));
        tick(); chk_ctr("R7 above");
        lanes(3'b001, {8'h34, 8'h34, 8'h34}, {8'h01, 8'h01, 8'h01}, 5'd0);
        tick(); chk_ctr("R7 below");

        // R8 edge
        wr_cfg(mk_cfg(8'h34, 8'h01, 8'd1, 0, 1, 1));
        tick(); tick(); tick(); chk_ctr("R8 held true");
        lanes(3'b000, '0, '0, 5'd0);
        tick(); chk_ctr("R8 false");
        lanes(3'b001, {8'h34, 8'h34, 8'h34}, {8'h01, 8'h01, 8'h01}, 5'd0);
        tick(); chk_ctr("R8 second rise");

        // R9 rearm on config write
        wr_cfg(mk_cfg(8'h34, 8'h01, 8'd1, 0, 1, 1));
        tick(); chk_ctr("R9 rearm");

        // R10 disabled
        wr_cfg(mk_cfg(8'h34, 8'h01, 8'd0, 0, 0, 0));
        tick(); tick(); chk_ctr("R10 disabled");

        // R11 write priority, R13 old config counts in write cycle
        wr_cfg(mk_cfg(8'h80, 8'h01, 8'd0, 0, 0, 1));
        lanes(3'b000, '0, '0, 5'd7);
        wr_ctr(48'h1234);
        chk_ctr("R11 write wins");
        check_val("R11 absolute", reg_rdata, 48'h1234);
        wr_cfg(mk_cfg(8'h80, 8'h01, 8'd0, 0, 0, 0));
        chk_ctr("R13 old config in write cycle");
        tick(); chk_ctr("R13 new config");

        // R12 wrap
        wr_cfg(mk_cfg(8'h80, 8'h01, 8'd0, 0, 0, 1));
        wr_ctr(48'hFFFF_FFFF_FFFE);
        lanes(3'b000, '0, '0, 5'd5);
        tick(); chk_ctr("R12 wrap");
        check_val("R12 absolute", reg_rdata, 48'd3);

        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [8*NL-1:0] c, a;
            for (int i = 0; i < NL; i++) begin
                c[8*i +: 8] = pick_code();
                a[8*i +: 8] = 8'($urandom);
            end
            lanes(NL'($urandom), c, a, OW'($urandom));
            if (k % 16 == 0)
                wr_cfg(mk_cfg(pick_code(), 8'($urandom), 8'($urandom % 4),
                              1'($urandom), 1'($urandom), ($urandom % 4) != 0));
            else if (k % 53 == 0)
                wr_ctr(CW'({$urandom, $urandom}));
            else
                tick();
            chk_ctr("R6/R7/R8 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule